// File: doc/BRIEF.md
# Indexed Codec Control Register File

This block is the byte-wide control front end of an audio codec. A host reaches it through four direct byte ports: an index pointer, a data window, a status byte and a programmed-I/O byte. Behind the data window sit 32 indirect 8-bit control registers, selected by the index pointer. Each indirect register follows its own write rule: some are fully writable, some keep reserved bits at zero, one is read-only, a few ignore every write, and the sample-format register only accepts writes while a mode-change window is open.

The index pointer also carries the mode-change enable bit. Raising it while the interface-configuration register requests auto-calibration arms a short calibration-busy indication that software sees by polling the read-only error/status register. A single event input stands for the playback interrupt source and sets the interrupt flag, which the host clears by writing the status port. Whenever the format register or the interface-configuration register accepts a write, the block emits a one-cycle pulse so that playback logic can reconfigure.

Top module: `codec_ctrl_regfile`

## Requirements
- R1: Port offset 0 is the index pointer, 1 the data window, 2 status, 3 programmed-I/O. The index pointer stores write data bits 6:0 and reads back with bit 7 equal to 0. Port 3 always reads 0x00 and ignores writes.
- R2: After reset the index pointer reads 0x40 and indirect registers hold: 0x88 at 2, 3, 4, 5, 18, 19; 0x80 at 6, 7; 0x08 at 9; 0x8A at 12; 0xA0 at 25, 26; 0x00 elsewhere. Status reads 0x00, irq and cfg_pulse are low.
- R3: The data window selects indirect register index[3:0] when bit 6 of register 12 is 0, and index[4:0] when it is 1.
- R4: A write to register 8 is stored whole when index bit 6 is 1; when index bit 6 is 0 and bit 4 of register 24 is 1, only bits 7:4 change; otherwise the write is dropped.
- R5: Register 9 always stores bit 5 as 0. Of register 12 only bit 6 is writable; its other bits keep the value 0x8A has there.
- R6: Register 11 and registers 22, 27 and 29 ignore writes (they read 0x00 apart from the R7 flag).
- R7: When an index write takes bit 6 from 0 to 1 while bits 4:3 of register 9 are nonzero, a calibration counter loads 1. A data-window read of register 11 with the counter nonzero returns bit 5 set and decrements the counter; otherwise bit 5 reads 0.
- R8: evt_irq sets the interrupt flag (status bit 0, driven on irq) and bit 4 of register 24. Any write to port 2 clears the flag and bits 6:4 of register 24; a simultaneous evt_irq wins.
- R9: cfg_pulse is high for exactly the cycle after a write to register 8 or 9 is accepted (a partial register-8 write counts; a dropped one does not).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 2 | Direct port offset |
| host_wdata | input | 8 | Write data |
| host_wr | input | 1 | Single-cycle write strobe |
| host_rd | input | 1 | Single-cycle read strobe |
| host_rdata | output | 8 | Read data, combinational from host_addr |
| evt_irq | input | 1 | Playback interrupt event |
| irq | output | 1 | Interrupt flag |
| cfg_pulse | output | 1 | Reconfigure pulse after accepted format/config write |

## Verification
Every cycle the assertions check that the index pointer reads with bit 7 clear and stores exactly the written low seven bits, that port 3 reads zero, that a format write with the window closed leaves the register stable or changes only its upper nibble when partial access is open, that a status write clears the flag and the pending bits, and that every cfg_pulse follows a data-window write. The bench alone shows the reset values, the switch between 4-bit and 5-bit indexing, the write masks of registers 9 and 12, the ignored registers, and the calibration flag appearing once and then clearing, as well as its absence when register 9 requests no calibration.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
   localparam int unsigned REG_FMT   = 8;
   localparam int unsigned REG_IFCFG = 9;
   localparam int unsigned REG_ERRST = 11;
   localparam int unsigned REG_MODE  = 12;
   localparam int unsigned REG_ALTST = 24;

   typedef enum logic [1:0] {
      PORT_INDEX  = 2'd0,
      PORT_DATA   = 2'd1,
      PORT_STATUS = 2'd2,
      PORT_PIO    = 2'd3
   } port_e;

   function automatic logic [7:0] reset_value(int unsigned i);
      case (i)
         2, 3, 4, 5, 18, 19: return 8'h88;
         6, 7:               return 8'h80;
         9:                  return 8'h08;
         12:                 return 8'h8A;
         25, 26:             return 8'hA0;
         default:            return 8'h00;
      endcase
   endfunction

   function automatic bit is_frozen(int unsigned i);
      return (i == 22) || (i == 27) || (i == 29) || (i == REG_ERRST);
   endfunction
endpackage

// File: rtl/ccr_index_port.sv
module ccr_index_port #(
   parameter int IDX_W    = 7,
   parameter int CAL_LOAD = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             idx_wr,
   input  logic [IDX_W-1:0] idx_wdata,
   input  logic [1:0]       cal_req,
   input  logic             cal_rd,
   output logic [IDX_W-1:0] idx_q,
   output logic             cal_busy
);
   localparam int CNT_W = $clog2(CAL_LOAD + 1) < 1 ? 1 : $clog2(CAL_LOAD + 1);
   localparam logic [IDX_W-1:0] IDX_RST = IDX_W'(8'h40);

   logic [CNT_W-1:0] cal_cnt;
   logic             mce_rise;

   assign mce_rise = idx_wr && !idx_q[6] && idx_wdata[6] && (cal_req != 2'b00);
   assign cal_busy = (cal_cnt != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q   <= IDX_RST;
         cal_cnt <= '0;
      end else begin
         if (idx_wr) idx_q <= idx_wdata;
         if (mce_rise)
            cal_cnt <= CNT_W'(CAL_LOAD);
         else if (cal_rd && cal_busy)
            cal_cnt <= cal_cnt - 1'b1;
      end
   end
endmodule

// File: rtl/ccr_reg_bank.sv
module ccr_reg_bank
   import ccr_pkg::*;
#(
   parameter int NUM_REGS = 32,
   parameter int DATA_W   = 8,
   localparam int SEL_W   = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [DATA_W-1:0] wdata,
   input  logic              mce_open,
   input  logic              stat_clr,
   input  logic              evt_set,
   output logic [DATA_W-1:0] regs_q [NUM_REGS],
   output logic              cfg_accept
);
   logic fmt_hit, fmt_full, fmt_part, cfg_hit;

   assign fmt_hit    = wr_en && (wr_sel == SEL_W'(REG_FMT));
   assign fmt_full   = fmt_hit && mce_open;
   assign fmt_part   = fmt_hit && !mce_open && regs_q[REG_ALTST][4];
   assign cfg_hit    = wr_en && (wr_sel == SEL_W'(REG_IFCFG));
   assign cfg_accept = fmt_full || fmt_part || cfg_hit;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      localparam logic [DATA_W-1:0] RST = reset_value(i);
      if (is_frozen(i)) begin : g_frozen
         assign regs_q[i] = RST;
      end else if (i == REG_MODE) begin : g_mode
         logic mode2_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                             mode2_q <= RST[6];
            else if (wr_en && wr_sel == SEL_W'(i))  mode2_q <= wdata[6];
         end
         assign regs_q[i] = (RST & ~DATA_W'(8'h40)) | {{(DATA_W-7){1'b0}}, mode2_q, 6'b0};
      end else if (i == REG_FMT) begin : g_fmt
         logic [DATA_W-1:0] fmt_q;
         always_ff @(posedge clk) begin
            if (!rst_n)        fmt_q <= RST;
            else if (fmt_full) fmt_q <= wdata;
            else if (fmt_part) fmt_q <= {wdata[DATA_W-1:4], fmt_q[3:0]};
         end
         assign regs_q[i] = fmt_q;
      end else if (i == REG_ALTST) begin : g_alt
         logic [DATA_W-1:0] alt_q;
         logic [DATA_W-1:0] alt_nx;
         always_comb begin
            alt_nx = alt_q;
            if (wr_en && wr_sel == SEL_W'(i)) alt_nx = wdata;
            if (stat_clr) alt_nx[6:4] = 3'b000;
            if (evt_set)  alt_nx[4]   = 1'b1;
         end
         always_ff @(posedge clk) begin
            if (!rst_n) alt_q <= RST;
            else        alt_q <= alt_nx;
         end
         assign regs_q[i] = alt_q;
      end else begin : g_plain
         localparam logic [DATA_W-1:0] WMASK = (i == REG_IFCFG) ? ~DATA_W'(8'h20) : '1;
         logic [DATA_W-1:0] val_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                            val_q <= RST;
            else if (wr_en && wr_sel == SEL_W'(i)) val_q <= wdata & WMASK;
         end
         assign regs_q[i] = val_q;
      end
   end
endmodule

// File: rtl/ccr_read_mux.sv
module ccr_read_mux
   import ccr_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int IDX_W  = 7
) (
   input  logic [1:0]        port,
   input  logic [IDX_W-1:0]  idx_q,
   input  logic [DATA_W-1:0] sel_val,
   input  logic              cal_flag,
   input  logic              irq_q,
   output logic [DATA_W-1:0] rdata
);
   always_comb begin
      unique case (port_e'(port))
         PORT_INDEX:  rdata = {{(DATA_W-IDX_W){1'b0}}, idx_q};
         PORT_DATA:   rdata = sel_val | (cal_flag ? DATA_W'(8'h20) : '0);
         PORT_STATUS: rdata = {{(DATA_W-1){1'b0}}, irq_q};
         default:     rdata = '0;
      endcase
   end
endmodule

// File: rtl/codec_ctrl_regfile.sv
module codec_ctrl_regfile
   import ccr_pkg::*;
#(
   parameter int NUM_REGS = 32,
   parameter int DATA_W   = 8,
   parameter int CAL_LOAD = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              host_wr,
   input  logic              host_rd,
   output logic [DATA_W-1:0] host_rdata,
   input  logic              evt_irq,
   output logic              irq,
   output logic              cfg_pulse
);
   localparam int SEL_W = $clog2(NUM_REGS);
   localparam int IDX_W = DATA_W - 1;

   if (DATA_W != 8) begin : g_bad_width
      $error("codec_ctrl_regfile: DATA_W must be 8");
   end
   if (NUM_REGS != 32) begin : g_bad_depth
      $error("codec_ctrl_regfile: NUM_REGS must be 32");
   end
   if (CAL_LOAD < 1) begin : g_bad_cal
      $error("codec_ctrl_regfile: CAL_LOAD must be at least 1");
   end

   logic [IDX_W-1:0]  idx_q;
   logic              cal_busy;
   logic [DATA_W-1:0] regs_q [NUM_REGS];
   logic [SEL_W-1:0]  data_sel;
   logic              mode2;
   logic              wr_idx, wr_data, wr_stat, rd_cal;
   logic              cfg_accept;
   logic              irq_q, pulse_q;
   logic [DATA_W-1:0] reg_fmt, reg_alt;

   assign mode2    = regs_q[REG_MODE][6];
   assign data_sel = mode2 ? SEL_W'(idx_q[4:0]) : SEL_W'({1'b0, idx_q[3:0]});
   assign wr_idx   = host_wr && (port_e'(host_addr) == PORT_INDEX);
   assign wr_data  = host_wr && (port_e'(host_addr) == PORT_DATA);
   assign wr_stat  = host_wr && (port_e'(host_addr) == PORT_STATUS);
   assign rd_cal   = host_rd && (port_e'(host_addr) == PORT_DATA)
                     && (data_sel == SEL_W'(REG_ERRST));
   assign reg_fmt  = regs_q[REG_FMT];
   assign reg_alt  = regs_q[REG_ALTST];

   ccr_index_port #(.IDX_W(IDX_W), .CAL_LOAD(CAL_LOAD)) u_index (
      .clk       (clk),
      .rst_n     (rst_n),
      .idx_wr    (wr_idx),
      .idx_wdata (host_wdata[IDX_W-1:0]),
      .cal_req   (regs_q[REG_IFCFG][4:3]),
      .cal_rd    (rd_cal),
      .idx_q     (idx_q),
      .cal_busy  (cal_busy)
   );

   ccr_reg_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_data),
      .wr_sel     (data_sel),
      .wdata      (host_wdata),
      .mce_open   (idx_q[6]),
      .stat_clr   (wr_stat),
      .evt_set    (evt_irq),
      .regs_q     (regs_q),
      .cfg_accept (cfg_accept)
   );

   ccr_read_mux #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_rmux (
      .port     (host_addr),
      .idx_q    (idx_q),
      .sel_val  (regs_q[data_sel]),
      .cal_flag (cal_busy && (data_sel == SEL_W'(REG_ERRST))),
      .irq_q    (irq_q),
      .rdata    (host_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_q   <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         if (evt_irq)      irq_q <= 1'b1;
         else if (wr_stat) irq_q <= 1'b0;
         pulse_q <= cfg_accept;
      end
   end

   assign irq       = irq_q;
   assign cfg_pulse = pulse_q;
endmodule

// File: rtl/codec_ctrl_regfile_chk.sv
module codec_ctrl_regfile_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] host_addr,
   input logic [7:0] host_wdata,
   input logic       host_wr,
   input logic [7:0] host_rdata,
   input logic       evt_irq,
   input logic       irq,
   input logic       cfg_pulse,
   input logic [6:0] idx_q,
   input logic [4:0] data_sel,
   input logic [7:0] reg_fmt,
   input logic [7:0] reg_alt
);
   assert_index_bit7_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (host_addr == 2'd0) |-> (host_rdata[7] == 1'b0));

   assert_pio_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (host_addr == 2'd3) |-> (host_rdata == 8'h00));

   assert_index_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_addr == 2'd0) |=> (idx_q == $past(host_wdata[6:0])));

   assert_fmt_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_addr == 2'd1 && data_sel == 5'd8 && !idx_q[6] && !reg_alt[4])
      |=> $stable(reg_fmt));

   assert_fmt_nibble_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_addr == 2'd1 && data_sel == 5'd8 && !idx_q[6] && reg_alt[4])
      |=> (reg_fmt[3:0] == $past(reg_fmt[3:0])));

   assert_status_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_addr == 2'd2 && !evt_irq) |=> (!irq && reg_alt[6:4] == 3'b000));

   assert_evt_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
      evt_irq |=> (irq && reg_alt[4]));

   assert_pulse_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_pulse |-> ($past(host_wr) && $past(host_addr) == 2'd1));
endmodule

bind codec_ctrl_regfile codec_ctrl_regfile_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_addr  (host_addr),
   .host_wdata (host_wdata),
   .host_wr    (host_wr),
   .host_rdata (host_rdata),
   .evt_irq    (evt_irq),
   .irq        (irq),
   .cfg_pulse  (cfg_pulse),
   .idx_q      (idx_q),
   .data_sel   (data_sel),
   .reg_fmt    (reg_fmt),
   .reg_alt    (reg_alt)
);

// File: tb/codec_ctrl_regfile_bench.sv
module codec_ctrl_regfile_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] host_addr = 2'd0;
   logic [7:0] host_wdata = 8'h00;
   logic       host_wr = 1'b0;
   logic       host_rd = 1'b0;
   logic [7:0] host_rdata;
   logic       evt_irq = 1'b0;
   logic       irq, cfg_pulse;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   codec_ctrl_regfile u_codec_ctrl_regfile (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
      .evt_irq(evt_irq), .irq(irq), .cfg_pulse(cfg_pulse)
   );

   // {is_write, port, write data, expected read data}
   localparam int NVEC = 31;
   localparam logic [18:0] VEC [NVEC] = '{
      {1'b0, 2'd0, 8'h00, 8'h40}, {1'b1, 2'd0, 8'h82, 8'h00}, {1'b0, 2'd0, 8'h00, 8'h02},
      {1'b0, 2'd1, 8'h00, 8'h88}, {1'b1, 2'd0, 8'h07, 8'h00}, {1'b0, 2'd1, 8'h00, 8'h80},
      {1'b1, 2'd0, 8'h0C, 8'h00}, {1'b0, 2'd1, 8'h00, 8'h8A}, {1'b1, 2'd1, 8'hFF, 8'h00},
      {1'b0, 2'd1, 8'h00, 8'hCA}, {1'b1, 2'd0, 8'h19, 8'h00}, {1'b0, 2'd1, 8'h00, 8'hA0},
      {1'b1, 2'd0, 8'h12, 8'h00}, {1'b0, 2'd1, 8'h00, 8'h88}, {1'b1, 2'd0, 8'h16, 8'h00},
      {1'b1, 2'd1, 8'h55, 8'h00}, {1'b0, 2'd1, 8'h00, 8'h00}, {1'b1, 2'd0, 8'h0B, 8'h00},
      {1'b1, 2'd1, 8'hFF, 8'h00}, {1'b0, 2'd1, 8'h00, 8'h00}, {1'b1, 2'd0, 8'h09, 8'h00},
      {1'b1, 2'd1, 8'hFF, 8'h00}, {1'b0, 2'd1, 8'h00, 8'hDF}, {1'b1, 2'd3, 8'h77, 8'h00},
      {1'b0, 2'd3, 8'h00, 8'h00}, {1'b0, 2'd2, 8'h00, 8'h00}, {1'b1, 2'd0, 8'h0C, 8'h00},
      {1'b1, 2'd1, 8'h00, 8'h00}, {1'b0, 2'd1, 8'h00, 8'h8A}, {1'b1, 2'd0, 8'h19, 8'h00},
      {1'b0, 2'd1, 8'h00, 8'hDF}
   };

   task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      host_addr = a; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      host_addr = a; host_rd = 1'b1;
      #5 d = host_rdata;
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [1:0] a, input logic [7:0] exp);
      logic [7:0] v;
      rd(a, v);
      check(tag, v, exp);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R2 irq after reset", {7'b0, irq}, 8'h00);
      check("R2 cfg_pulse after reset", {7'b0, cfg_pulse}, 8'h00);

      // vector walk: R1 port map, R2 reset values, R3 index width, R5 masks, R6 ignored
      for (int k = 0; k < NVEC; k++) begin
         if (VEC[k][18]) wr(VEC[k][17:16], VEC[k][15:8]);
         else rd_chk($sformatf("R1/R2/R3/R5/R6 vector %0d", k), VEC[k][17:16], VEC[k][7:0]);
      end

      // R4: window closed, no partial access -> dropped, no pulse (R9)
      wr(2'd0, 8'h08);
      wr(2'd1, 8'hFF);
      check("R9 no pulse on dropped write", {7'b0, cfg_pulse}, 8'h00);
      rd_chk("R4 locked format write", 2'd1, 8'h00);

      // R4 full write with mode-change enable, also arms calibration (R7)
      wr(2'd0, 8'h48);
      wr(2'd1, 8'h5A);
      check("R9 pulse after format write", {7'b0, cfg_pulse}, 8'h01);
      @(negedge clk);
      check("R9 pulse lasts one cycle", {7'b0, cfg_pulse}, 8'h00);
      rd_chk("R4 full format write", 2'd1, 8'h5A);

      wr(2'd0, 8'h4B);
      rd_chk("R7 calibration flag first read", 2'd1, 8'h20);
      rd_chk("R7 calibration flag cleared", 2'd1, 8'h00);

      // R4 partial write: 5-bit mode, set register 24 bit 4
      wr(2'd0, 8'h0C);
      wr(2'd1, 8'h40);
      wr(2'd0, 8'h18);
      wr(2'd1, 8'h7F);
      rd_chk("R3 register 24 reached in 5-bit mode", 2'd1, 8'h7F);
      wr(2'd0, 8'h08);
      wr(2'd1, 8'hA3);
      check("R9 pulse after partial format write", {7'b0, cfg_pulse}, 8'h01);
      rd_chk("R4 upper nibble only", 2'd1, 8'hAA);

      // R8 interrupt event and status clear
      @(negedge clk); evt_irq = 1'b1;
      @(negedge clk); evt_irq = 1'b0;
      check("R8 irq set by event", {7'b0, irq}, 8'h01);
      rd_chk("R8 status bit 0", 2'd2, 8'h01);
      wr(2'd0, 8'h18);
      rd_chk("R8 register 24 before clear", 2'd1, 8'h7F);
      wr(2'd2, 8'h00);
      check("R8 irq cleared by status write", {7'b0, irq}, 8'h00);
      rd_chk("R8 register 24 bits 6:4 cleared", 2'd1, 8'h0F);
      rd_chk("R8 status after clear", 2'd2, 8'h00);

      // R5/R9 register 9 write, then R7 no calibration when bits 4:3 are zero
      wr(2'd0, 8'h09);
      wr(2'd1, 8'h20);
      check("R9 pulse after config write", {7'b0, cfg_pulse}, 8'h01);
      rd_chk("R5 register 9 bit 5 dropped", 2'd1, 8'h00);
      wr(2'd0, 8'h4B);
      rd_chk("R7 no calibration without request", 2'd1, 8'h00);
      rd_chk("R1 index readback", 2'd0, 8'h4B);

      finish_run();
   end
endmodule